// File: doc/BRIEF.md
# Target Delayed Transaction Controller

This block is the target-side control for split (delayed) completions on a parallel shared bus. Every accepted request must see an answer, retry or completion, within a fixed initial-phase window. A request that does not need a posted path is copied into a single record and handed to the backend. If the backend answers inside the window, the request completes directly. If it does not, the initiator is told to retry while the backend access runs on. The result is kept until the initiator repeats the identical request, which then completes at once with the stored data.

Memory writes take a posted path. They complete on the next clock and are forwarded to the backend without creating a record. While a record is held, any request that is not its exact repeat is retried without being recorded. It can be taken once the held one has been claimed or dropped. A record whose result is never claimed is dropped after a fixed number of idle clocks.

Usage rule: requests are single-cycle pulses on `req_valid`. A new request is presented only after the answer to the previous one has been seen.

Top module: `dly_txn_target`

## Requirements
- R1: After each accepted request exactly one response appears: a one-clock pulse on `resp_retry` or on `resp_done`, never both. It is visible no later than the output update at clock edge INIT_LIMIT-1, counting the edge that samples the request as edge 0.
- R2: Conditions: the command is not a memory write, there is no record and the backend is idle. The request is then recorded, and `be_start` pulses after edge 0 with the request's command, address, byte enables and write data. If `be_ack` is sampled at edge k with 1 ≤ k ≤ INIT_LIMIT-1, `resp_done` follows after edge k, carrying `be_rdata` for a read. Otherwise `resp_retry` follows after edge INIT_LIMIT-1.
- R3: While the backend access of a record is still outstanding, every request is answered by `resp_retry` after edge 0 and starts nothing.
- R4: Once the record's result has arrived, a repeat request answers `resp_done` after edge 0 and clears the record. For a read (command bit 0 = 0) it carries the stored read data. A repeat has equal command, address and byte enables, and also equal write data when the command is a write (command bit 0 = 1).
- R5: A request differing from the record in any compared field answers `resp_retry` after edge 0 and starts nothing. The record is kept, so a later exact repeat still completes.
- R6: For a read command (bit 0 = 0), `req_wdata` takes no part in the comparison.
- R7: A memory write (command 4'b0111) arriving while the backend is idle answers `resp_done` after edge 0 and starts the backend with its fields, without a record. If the backend is busy it is answered by `resp_retry` and starts nothing.
- R8: After a record has been claimed, the next non-posted request is recorded and started as in R2.
- R9: A result held unclaimed for DISCARD_CLKS clocks is dropped. A later identical request is then treated as new and starts the backend again.
- R10: The backend is started exactly once per record, however many repeats arrive. It is never started while a previous access is outstanding.
- R11: After reset, `resp_retry`, `resp_done` and `be_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Decoded request present (one clock) |
| req_cmd | input | 4 | Bus command; bit 0 = write |
| req_addr | input | AW | Request address |
| req_be | input | DW/8 | Byte enables |
| req_wdata | input | DW | Write data |
| resp_retry | output | 1 | Tell initiator to retry |
| resp_done | output | 1 | Request completed |
| resp_rdata | output | DW | Read data with completion |
| be_start | output | 1 | Start one backend access |
| be_cmd | output | 4 | Backend command |
| be_addr | output | AW | Backend address |
| be_be | output | DW/8 | Backend byte enables |
| be_wdata | output | DW | Backend write data |
| be_ack | input | 1 | Backend access finished |
| be_rdata | input | DW | Backend read data, valid with be_ack |

## Verification
The assertions watch, on every cycle, that retry and completion never coincide. They also check that every accepted request is answered inside the initial-phase window, that a backend start always follows a request, and that no start is issued while an access is outstanding. Only the bench scenarios can show the split between direct and delayed completion as backend latency sweeps across the window. The same holds for the field-exact matching and the insensitivity of reads to write data, the posted-write path, and the discarding of an unclaimed result. Each is checked against data and latencies computed in the bench.

// File: rtl/dly_txn_pkg.sv
package dly_txn_pkg;

  localparam int CMD_W = 4;

  typedef logic [CMD_W-1:0] cmd_t;

  // Posted memory write code; bit 0 of every command marks a write.
  localparam cmd_t CMD_MEM_WR = 4'b0111;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PEND,
    ST_READY
  } ctl_state_e;

  typedef enum logic [1:0] {
    RS_NONE,
    RS_DIRECT,
    RS_BUF
  } rsel_e;

  function automatic logic cmd_is_write(cmd_t c);
    return c[0];
  endfunction

endpackage

// File: rtl/dly_txn_tick.sv
module dly_txn_tick #(
  parameter int TERM = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic last
);

  localparam int CW = (TERM < 2) ? 1 : $clog2(TERM + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == CW'(TERM));

endmodule

// File: rtl/dly_txn_entry.sv
module dly_txn_entry
  import dly_txn_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int BE_W = DW / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  cmd_t            req_cmd,
  input  logic [AW-1:0]   req_addr,
  input  logic [BE_W-1:0] req_be,
  input  logic [DW-1:0]   req_wdata,
  input  logic            buf_load,
  input  logic [DW-1:0]   buf_data,
  output logic            hit,
  output logic [DW-1:0]   buf_q
);

  cmd_t            rec_cmd_q;
  logic [AW-1:0]   rec_addr_q;
  logic [BE_W-1:0] rec_be_q;
  logic [DW-1:0]   rec_wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_cmd_q   <= '0;
      rec_addr_q  <= '0;
      rec_be_q    <= '0;
      rec_wdata_q <= '0;
    end else if (load) begin
      rec_cmd_q   <= req_cmd;
      rec_addr_q  <= req_addr;
      rec_be_q    <= req_be;
      rec_wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (buf_load) begin
      buf_q <= buf_data;
    end
  end

  logic same_hdr;
  logic same_data;

  always_comb begin
    same_hdr  = (req_cmd == rec_cmd_q) && (req_addr == rec_addr_q) &&
                (req_be == rec_be_q);
    same_data = !cmd_is_write(req_cmd) || (req_wdata == rec_wdata_q);
    hit       = same_hdr && same_data;
  end

endmodule

// File: rtl/dly_txn_fsm.sv
module dly_txn_fsm
  import dly_txn_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  logic  req_post,
  input  logic  hit,
  input  logic  bk_ack,
  input  logic  dl_last,
  input  logic  dc_last,
  output logic  start,
  output logic  rty,
  output logic  dn,
  output rsel_e rsel,
  output logic  ent_ld,
  output logic  buf_ld,
  output logic  dl_clr,
  output logic  dl_en,
  output logic  dc_clr,
  output logic  dc_en
);

  ctl_state_e st_q;
  ctl_state_e st_d;
  logic       busy_q;
  logic       busy_d;

  always_comb begin
    st_d   = st_q;
    start  = 1'b0;
    rty    = 1'b0;
    dn     = 1'b0;
    rsel   = RS_NONE;
    ent_ld = 1'b0;
    buf_ld = 1'b0;
    dl_clr = 1'b0;
    dl_en  = 1'b0;
    dc_clr = 1'b0;
    dc_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_post) begin
            if (!busy_q) begin
              start = 1'b1;
              dn    = 1'b1;
            end else begin
              rty = 1'b1;
            end
          end else if (busy_q) begin
            rty = 1'b1;
          end else begin
            start  = 1'b1;
            ent_ld = 1'b1;
            dl_clr = 1'b1;
            st_d   = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (bk_ack) begin
          dn   = 1'b1;
          rsel = RS_DIRECT;
          st_d = ST_IDLE;
        end else if (dl_last) begin
          rty  = 1'b1;
          st_d = ST_PEND;
        end else begin
          dl_en = 1'b1;
        end
      end
      ST_PEND: begin
        if (req_valid) begin
          rty = 1'b1;
        end
        if (bk_ack) begin
          buf_ld = 1'b1;
          dc_clr = 1'b1;
          st_d   = ST_READY;
        end
      end
      ST_READY: begin
        if (req_valid && hit && !req_post) begin
          dn   = 1'b1;
          rsel = RS_BUF;
          st_d = ST_IDLE;
        end else begin
          if (req_valid) begin
            if (req_post && !busy_q) begin
              start = 1'b1;
              dn    = 1'b1;
            end else begin
              rty = 1'b1;
            end
          end
          if (dc_last) begin
            st_d = ST_IDLE;
          end else begin
            dc_en = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
    end else if (bk_ack) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      busy_q <= busy_d;
    end
  end

endmodule

// File: rtl/dly_txn_target.sv
module dly_txn_target
  import dly_txn_pkg::*;
#(
  parameter int AW           = 32,
  parameter int DW           = 32,
  parameter int INIT_LIMIT   = 16,
  parameter int DISCARD_CLKS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_cmd,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW/8-1:0]   req_be,
  input  logic [DW-1:0]     req_wdata,
  output logic              resp_retry,
  output logic              resp_done,
  output logic [DW-1:0]     resp_rdata,
  output logic              be_start,
  output logic [3:0]        be_cmd,
  output logic [AW-1:0]     be_addr,
  output logic [DW/8-1:0]   be_be,
  output logic [DW-1:0]     be_wdata,
  input  logic              be_ack,
  input  logic [DW-1:0]     be_rdata
);

  localparam int BE_W    = DW / 8;
  localparam int DL_TERM = INIT_LIMIT - 2;
  localparam int DC_TERM = DISCARD_CLKS - 1;

  logic    req_post;
  logic    hit;
  logic    start, rty, dn;
  rsel_e   rsel;
  logic    ent_ld, buf_ld;
  logic    dl_clr, dl_en, dl_last;
  logic    dc_clr, dc_en, dc_last;
  logic [DW-1:0] buf_q;
  logic [DW-1:0] rdata_d;

  assign req_post = (cmd_t'(req_cmd) == CMD_MEM_WR);

  dly_txn_entry #(
    .AW   (AW),
    .DW   (DW),
    .BE_W (BE_W)
  ) u_entry (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ent_ld),
    .req_cmd   (cmd_t'(req_cmd)),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_wdata (req_wdata),
    .buf_load  (buf_ld),
    .buf_data  (be_rdata),
    .hit       (hit),
    .buf_q     (buf_q)
  );

  dly_txn_tick #(.TERM(DL_TERM)) u_deadline (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (dl_clr),
    .en    (dl_en),
    .last  (dl_last)
  );

  dly_txn_tick #(.TERM(DC_TERM)) u_discard (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (dc_clr),
    .en    (dc_en),
    .last  (dc_last)
  );

  dly_txn_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_post  (req_post),
    .hit       (hit),
    .bk_ack    (be_ack),
    .dl_last   (dl_last),
    .dc_last   (dc_last),
    .start     (start),
    .rty       (rty),
    .dn        (dn),
    .rsel      (rsel),
    .ent_ld    (ent_ld),
    .buf_ld    (buf_ld),
    .dl_clr    (dl_clr),
    .dl_en     (dl_en),
    .dc_clr    (dc_clr),
    .dc_en     (dc_en)
  );

  always_comb begin
    unique case (rsel)
      RS_DIRECT: rdata_d = be_rdata;
      RS_BUF:    rdata_d = buf_q;
      default:   rdata_d = '0;
    endcase
  end

  // Response pulses and read data.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_retry <= 1'b0;
      resp_done  <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_retry <= rty;
      resp_done  <= dn;
      if (dn) begin
        resp_rdata <= rdata_d;
      end
    end
  end

  // Backend request, fields loaded only with a start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_start <= 1'b0;
      be_cmd   <= '0;
      be_addr  <= '0;
      be_be    <= '0;
      be_wdata <= '0;
    end else begin
      be_start <= start;
      if (start) begin
        be_cmd   <= req_cmd;
        be_addr  <= req_addr;
        be_be    <= req_be;
        be_wdata <= req_wdata;
      end
    end
  end

endmodule

// File: rtl/dly_txn_chk.sv
module dly_txn_chk #(
  parameter int INIT_LIMIT = 16
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic resp_retry,
  input logic resp_done,
  input logic be_start,
  input logic be_ack
);

  localparam int CW = $clog2(INIT_LIMIT) + 2;
  localparam logic [CW-1:0] CMAX = '1;

  logic          pend_q;
  logic [CW-1:0] wait_q;
  logic          out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wait_q <= '0;
    end else if (req_valid) begin
      pend_q <= 1'b1;
      wait_q <= '0;
    end else if (pend_q && (resp_retry || resp_done)) begin
      pend_q <= 1'b0;
    end else if (pend_q && (wait_q != CMAX)) begin
      wait_q <= wait_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else if (be_start) begin
      out_q <= 1'b1;
    end else if (be_ack) begin
      out_q <= 1'b0;
    end
  end

  p_excl_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_retry && resp_done));

  p_deadline_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (wait_q < CW'(INIT_LIMIT)));

  p_start_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |-> !out_q);

  p_start_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |-> $past(req_valid));

endmodule

bind dly_txn_target dly_txn_chk #(.INIT_LIMIT(INIT_LIMIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .resp_retry (resp_retry),
  .resp_done  (resp_done),
  .be_start   (be_start),
  .be_ack     (be_ack)
);

// File: tb/dly_txn_target_tb.sv
module dly_txn_target_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LIM        = 16;
  localparam int DISC       = 1024;
  localparam logic [31:0] KEY = 32'h5A5A_0F0F;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_cmd;
  logic [31:0] req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        resp_retry, resp_done;
  logic [31:0] resp_rdata;
  logic        be_start;
  logic [3:0]  be_cmd;
  logic [31:0] be_addr;
  logic [3:0]  be_be;
  logic [31:0] be_wdata;
  logic        be_ack;
  logic [31:0] be_rdata;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  int lat    = 1;
  logic [7:0]  bk_cnt;
  logic [31:0] bk_addr;

  dly_txn_target #(.AW(32), .DW(32), .INIT_LIMIT(LIM), .DISCARD_CLKS(DISC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .resp_retry(resp_retry), .resp_done(resp_done), .resp_rdata(resp_rdata),
    .be_start(be_start), .be_cmd(be_cmd), .be_addr(be_addr), .be_be(be_be),
    .be_wdata(be_wdata), .be_ack(be_ack), .be_rdata(be_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Backend model: ack sampled L edges after the edge that sees be_start.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bk_cnt  <= '0;
      bk_addr <= '0;
    end else if (be_start) begin
      bk_cnt  <= 8'(lat);
      bk_addr <= be_addr;
      starts  <= starts + 1;
    end else if (bk_cnt != 0) begin
      bk_cnt <= bk_cnt - 1'b1;
    end
  end
  assign be_ack   = (bk_cnt == 8'd1);
  assign be_rdata = bk_addr ^ KEY;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // kind: 0 none, 1 retry, 2 done; n = edges after the sampling edge.
  task automatic issue(input logic [3:0] c, input logic [31:0] a, input logic [3:0] b,
                       input logic [31:0] w, output int kind, output int n,
                       output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_be = b; req_wdata = w;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; kind = 0; rd = '0;
    while (kind == 0 && n < 64) begin
      if (resp_done) begin kind = 2; rd = resp_rdata; end
      else if (resp_retry) kind = 1;
      else begin @(negedge clk); n++; end
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  logic [3:0] cmds [5];

  initial begin
    int kind, n, s0;
    logic [31:0] rd;
    cmds[0] = 4'b0010; cmds[1] = 4'b0110; cmds[2] = 4'b1010;
    cmds[3] = 4'b0011; cmds[4] = 4'b1011;
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_addr = '0; req_be = '0;
    req_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk(!resp_retry && !resp_done && !be_start, "R11 reset outputs",
        {29'd0, resp_retry, resp_done, be_start}, 0);

    // R2/R3/R4/R10 sweep of latency against the window, all non-posted commands.
    for (int L = 1; L <= 20; L++) begin
      for (int ci = 0; ci < 5; ci++) begin
        logic [31:0] a;
        logic [3:0]  b;
        a = 32'h1000_0000 + (L << 8) + (ci << 4);
        b = 4'(L + ci);
        lat = L;
        s0 = starts;
        issue(cmds[ci], a, b, a + 32'h77, kind, n, rd);
        if (L <= LIM - 2) begin
          chk(kind == 2 && n == L + 1, "R2 direct done timing", n, L + 1);
          if (!cmds[ci][0]) chk(rd == (a ^ KEY), "R2 direct rdata", rd, a ^ KEY);
        end else begin
          chk(kind == 1 && n == LIM - 1, "R2 retry at window end", n, LIM - 1);
          if (L >= 18) begin
            issue(cmds[ci], a, b, a + 32'h77, kind, n, rd);
            chk(kind == 1 && n == 0, "R3 retry while outstanding", kind, 1);
          end
          idle(L + 2);
          issue(cmds[ci], a, b, a + 32'h77, kind, n, rd);
          chk(kind == 2 && n == 0, "R4 repeat completes", kind, 2);
          if (!cmds[ci][0]) chk(rd == (a ^ KEY), "R4 buffered rdata", rd, a ^ KEY);
        end
        idle(1);
        chk(starts == s0 + 1, "R10 one start per request", starts - s0, 1);
      end
    end

    // R5/R6/R8: mismatches while a result is held.
    lat = 30;
    s0 = starts;
    issue(4'b0110, 32'h2000_0040, 4'hF, 32'h0, kind, n, rd);
    chk(kind == 1, "R2 record read", kind, 1);
    idle(40);
    issue(4'b0110, 32'h2000_0044, 4'hF, 32'h0, kind, n, rd);
    chk(kind == 1 && n == 0, "R5 addr mismatch retried", kind, 1);
    issue(4'b0110, 32'h2000_0040, 4'h3, 32'h0, kind, n, rd);
    chk(kind == 1 && n == 0, "R5 be mismatch retried", kind, 1);
    issue(4'b0010, 32'h2000_0040, 4'hF, 32'h0, kind, n, rd);
    chk(kind == 1 && n == 0, "R5 cmd mismatch retried", kind, 1);
    chk(starts == s0 + 1, "R5 no start on mismatch", starts - s0, 1);
    issue(4'b0110, 32'h2000_0040, 4'hF, 32'hDEAD_BEEF, kind, n, rd);
    chk(kind == 2 && rd == (32'h2000_0040 ^ KEY), "R6 read ignores wdata", rd,
        32'h2000_0040 ^ KEY);
    lat = 4;
    issue(4'b0110, 32'h2000_0044, 4'hF, 32'h0, kind, n, rd);
    chk(kind == 2 && n == 5 && rd == (32'h2000_0044 ^ KEY), "R8 next request taken",
        rd, 32'h2000_0044 ^ KEY);

    // R5 write data mismatch on a delayed write.
    lat = 30;
    s0 = starts;
    issue(4'b0011, 32'h3000_0000, 4'h1, 32'h0000_00AA, kind, n, rd);
    chk(kind == 1, "R2 record write", kind, 1);
    idle(40);
    issue(4'b0011, 32'h3000_0000, 4'h1, 32'h0000_00AB, kind, n, rd);
    chk(kind == 1 && n == 0, "R5 wdata mismatch retried", kind, 1);
    issue(4'b0011, 32'h3000_0000, 4'h1, 32'h0000_00AA, kind, n, rd);
    chk(kind == 2 && n == 0, "R4 write repeat completes", kind, 2);
    chk(starts == s0 + 1, "R10 write started once", starts - s0, 1);

    // R7 posted memory writes.
    lat = 10;
    s0 = starts;
    issue(4'b0111, 32'h4000_0000, 4'hF, 32'h1234_5678, kind, n, rd);
    chk(kind == 2 && n == 0, "R7 posted done", kind, 2);
    chk(be_cmd == 4'b0111 && be_wdata == 32'h1234_5678, "R7 posted fields", be_wdata,
        32'h1234_5678);
    issue(4'b0111, 32'h4000_0004, 4'hF, 32'h0, kind, n, rd);
    chk(kind == 1 && n == 0, "R7 posted retried while busy", kind, 1);
    issue(4'b0110, 32'h4000_0008, 4'hF, 32'h0, kind, n, rd);
    chk(kind == 1 && n == 0, "R10 no start while busy", kind, 1);
    idle(1);
    chk(starts == s0 + 1, "R7 one start", starts - s0, 1);
    idle(12);

    // R9 kept before the discard time, dropped after it.
    lat = 30;
    s0 = starts;
    issue(4'b1010, 32'h5000_0000, 4'hF, 32'h0, kind, n, rd);
    idle(600);
    issue(4'b1010, 32'h5000_0000, 4'hF, 32'h0, kind, n, rd);
    chk(kind == 2 && n == 0, "R9 held before discard", kind, 2);
    issue(4'b1010, 32'h5000_0010, 4'hF, 32'h0, kind, n, rd);
    idle(DISC + 100);
    issue(4'b1010, 32'h5000_0010, 4'hF, 32'h0, kind, n, rd);
    chk(kind == 1 && n == LIM - 1, "R9 dropped then fresh", n, LIM - 1);
    idle(1);
    chk(starts == s0 + 3, "R9 restarted backend", starts - s0, 3);
    idle(40);
    issue(4'b1010, 32'h5000_0010, 4'hF, 32'h0, kind, n, rd);
    chk(kind == 2 && rd == (32'h5000_0010 ^ KEY), "R4 claim after restart", rd,
        32'h5000_0010 ^ KEY);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule